// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides one input clock by an integer taken from a bit field of a control word. The output is never gated. A plain write port loads the control word. A build-time parameter chooses how the field value turns into a divisor. There are four choices:

- the value plus one;
- the value itself, with zero forbidden;
- two raised to the value;
- an entry of a small parameter table, where a zero entry marks a forbidden field value.

Every decoded divisor is checked against a configured minimum and maximum. A write that fails decoding is dropped and raises an error flag.

A new divisor waits until the running output period ends before it takes effect, so the output never shows a shortened pulse. Divide-by-one hands the input clock straight through. The same control word carries an autoidle enable bit at its own position. A parameter can invert that bit's meaning.

Top module: `regdiv_clock`

## Requirements
- R1: With ENC_MODE 0, field value v selects divisor v+1 (0 gives 1, 2 gives 3, 5 gives 6).
- R2: With ENC_MODE 1, field value v selects divisor v, and v = 0 is an illegal write.
- R3: With ENC_MODE 2, field value v selects divisor 2^v (2 gives 4, 4 gives 16).
- R4: With ENC_MODE 3, field value v selects table entry v (entry v occupies DIV_TABLE bits [v*DIV_W +: DIV_W]). A zero entry makes v illegal.
- R5: The field is wr_data[FLD_SHIFT +: FLD_W]. Bits outside the field and outside the autoidle bit have no effect on the divisor.
- R6: A decoded divisor below MIN_DIV or above MAX_DIV is an illegal write. The table encoding is also subject to this check.
- R7: An illegal write leaves the active divisor unchanged and sets bad_prog. bad_prog stays 1 until a legal write clears it.
- R8: A new divisor is applied only once the current output period has completed. The period during which the write occurs runs at the old divisor.
- R9: At divisor 1, clk_out equals clk.
- R10: At divisor N >= 2, the output period is N input cycles and the high phase is floor(N/2) input cycles.
- R11: autoidle_en follows wr_data[AI_SHIFT] on every write, inverted when AI_INV = 1. It is independent of divisor legality.
- R12: After reset, the divisor is RST_DIV (default 1, pass-through), bad_prog is 0 and autoidle_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | REG_W | Control word value |
| clk_out | output | 1 | Divided clock |
| bad_prog | output | 1 | Last write carried an illegal divisor |
| autoidle_en | output | 1 | Decoded autoidle enable |

## Verification
The bench goes after the forbidden codes in each encoding: a zero field in direct mode, a zero table entry, and power-of-two and plus-one values just beyond the limits. A divider that accepted any of them would change its measured period instead of keeping it and raising bad_prog.

For the period in progress when a write lands, the bench measures the length. A design that reloaded early would produce a runt, which shows up as a period that matches neither divisor.

The bench also measures the high phase of odd divisors and checks divide-by-one pass-through. These catch rounding the half period the wrong way and a counter that stalls at 1.

Garbage outside the field, and an inverted autoidle bit, expose a wrong shift or a wrong polarity.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;
  typedef enum logic [1:0] {
    ENC_PLUS1  = 2'd0,
    ENC_DIRECT = 2'd1,
    ENC_POW2   = 2'd2,
    ENC_TABLE  = 2'd3
  } enc_mode_e;
endpackage

// File: rtl/regdiv_decode.sv
module regdiv_decode #(
  parameter int REG_W     = 32,
  parameter int FLD_W     = 3,
  parameter int FLD_SHIFT = 0,
  parameter int DIV_W     = 8,
  parameter int ENC_MODE  = 0,
  parameter int MIN_DIV   = 1,
  parameter int MAX_DIV   = 127,
  parameter logic [(2**FLD_W)*DIV_W-1:0] DIV_TABLE = '0
) (
  input  logic [REG_W-1:0] word,
  output logic [DIV_W-1:0] div,
  output logic             ok
);
  import regdiv_pkg::*;
  localparam int EXT_W = DIV_W + 1;

  logic [FLD_W-1:0] fld;
  logic [EXT_W-1:0] raw;
  logic             code_ok;

  assign fld = word[FLD_SHIFT +: FLD_W];

  generate
    if (ENC_MODE == ENC_PLUS1) begin : g_plus1
      assign raw     = EXT_W'(fld) + EXT_W'(1);
      assign code_ok = 1'b1;
    end else if (ENC_MODE == ENC_DIRECT) begin : g_direct
      assign raw     = EXT_W'(fld);
      assign code_ok = (fld != '0);
    end else if (ENC_MODE == ENC_POW2) begin : g_pow2
      assign raw     = EXT_W'(1) << fld;
      assign code_ok = (int'(fld) < DIV_W);
    end else begin : g_table
      assign raw     = EXT_W'(DIV_TABLE[int'(fld)*DIV_W +: DIV_W]);
      assign code_ok = (raw != '0);
    end
  endgenerate

  always_comb begin
    ok  = code_ok && (int'(raw) >= MIN_DIV) && (int'(raw) <= MAX_DIV);
    div = raw[DIV_W-1:0];
  end
endmodule

// File: rtl/regdiv_ctrl.sv
module regdiv_ctrl #(
  parameter int REG_W    = 32,
  parameter int DIV_W    = 8,
  parameter int AI_SHIFT = 0,
  parameter bit AI_INV   = 1'b0,
  parameter int RST_DIV  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [DIV_W-1:0] dec_div,
  input  logic             dec_ok,
  output logic [DIV_W-1:0] pend_div,
  output logic             bad_q,
  output logic             ai_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div <= DIV_W'(RST_DIV);
      bad_q    <= 1'b0;
      ai_q     <= 1'b0;
    end else if (wr_en) begin
      ai_q <= wr_data[AI_SHIFT] ^ AI_INV;
      if (dec_ok) begin
        pend_div <= dec_div;
        bad_q    <= 1'b0;
      end else begin
        bad_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/regdiv_gen.sv
module regdiv_gen #(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] pend_div,
  output logic [DIV_W-1:0] cur_div,
  output logic [DIV_W-1:0] cnt_q,
  output logic             byp_q,
  output logic             clk_out
);
  logic             out_q;
  logic             at_end;
  logic [DIV_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + DIV_W'(1);
  assign at_end = byp_q || (cnt_nx == cur_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_div <= DIV_W'(RST_DIV);
      cnt_q   <= '0;
      byp_q   <= (RST_DIV == 1);
      out_q   <= (RST_DIV != 1);
    end else if (at_end) begin
      cur_div <= pend_div;
      cnt_q   <= '0;
      byp_q   <= (pend_div == DIV_W'(1));
      out_q   <= (pend_div != DIV_W'(1));
    end else begin
      cnt_q   <= cnt_nx;
      out_q   <= (cnt_nx < (cur_div >> 1));
    end
  end

  assign clk_out = byp_q ? clk : out_q;
endmodule

// File: rtl/regdiv_clock.sv
module regdiv_clock #(
  parameter int REG_W     = 32,
  parameter int FLD_W     = 3,
  parameter int FLD_SHIFT = 8,
  parameter int DIV_W     = 8,
  parameter int ENC_MODE  = 0,
  parameter int MIN_DIV   = 1,
  parameter int MAX_DIV   = 6,
  parameter int AI_SHIFT  = 0,
  parameter bit AI_INV    = 1'b0,
  parameter int RST_DIV   = 1,
  parameter logic [(2**FLD_W)*DIV_W-1:0] DIV_TABLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             clk_out,
  output logic             bad_prog,
  output logic             autoidle_en
);
  logic [DIV_W-1:0] dec_div;
  logic             dec_ok;
  logic [DIV_W-1:0] pend_div;
  logic [DIV_W-1:0] cur_div;
  logic [DIV_W-1:0] cnt_q;
  logic             byp_q;

  regdiv_decode #(
    .REG_W(REG_W), .FLD_W(FLD_W), .FLD_SHIFT(FLD_SHIFT), .DIV_W(DIV_W),
    .ENC_MODE(ENC_MODE), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .DIV_TABLE(DIV_TABLE)
  ) u_dec (
    .word(wr_data), .div(dec_div), .ok(dec_ok)
  );

  regdiv_ctrl #(
    .REG_W(REG_W), .DIV_W(DIV_W), .AI_SHIFT(AI_SHIFT), .AI_INV(AI_INV),
    .RST_DIV(RST_DIV)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dec_div(dec_div), .dec_ok(dec_ok), .pend_div(pend_div),
    .bad_q(bad_prog), .ai_q(autoidle_en)
  );

  regdiv_gen #(
    .DIV_W(DIV_W), .RST_DIV(RST_DIV)
  ) u_gen (
    .clk(clk), .rst(rst), .pend_div(pend_div), .cur_div(cur_div),
    .cnt_q(cnt_q), .byp_q(byp_q), .clk_out(clk_out)
  );
endmodule

// File: rtl/regdiv_chk.sv
module regdiv_chk #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             dec_ok,
  input logic             bad_prog,
  input logic             clk_out,
  input logic [DIV_W-1:0] pend_div,
  input logic [DIV_W-1:0] cur_div,
  input logic [DIV_W-1:0] cnt_q,
  input logic             byp_q
);
  assert_pend_range_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(pend_div) >= MIN_DIV) && (int'(pend_div) <= MAX_DIV));

  assert_bad_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dec_ok) |=> ($stable(pend_div) && bad_prog));

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bad_prog) |-> $past(wr_en));

  assert_reload_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (cur_div != $past(cur_div)) |-> (cnt_q == '0));

  assert_high_start_R10: assert property (@(posedge clk) disable iff (rst)
    (!byp_q && cnt_q == '0) |-> clk_out);

  assert_div_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    (cur_div != '0) && (byp_q == (cur_div == DIV_W'(1))));
endmodule

bind regdiv_clock regdiv_chk #(
  .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .dec_ok(dec_ok),
  .bad_prog(bad_prog), .clk_out(clk_out), .pend_div(pend_div),
  .cur_div(cur_div), .cnt_q(cnt_q), .byp_q(byp_q)
);

// File: tb/tb_regdiv_clock.sv
module tb_regdiv_clock;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  co, bad, ai;
  int          sel = 0;

  int nchk = 0;
  int nfail = 0;

  always #(CYC/2) clk = ~clk;

  regdiv_clock #(.ENC_MODE(0), .FLD_SHIFT(8), .MIN_DIV(1), .MAX_DIV(6),
    .AI_SHIFT(0), .AI_INV(1'b0), .RST_DIV(1)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data),
    .clk_out(co[0]), .bad_prog(bad[0]), .autoidle_en(ai[0]));

  regdiv_clock #(.ENC_MODE(1), .FLD_SHIFT(24), .MIN_DIV(1), .MAX_DIV(7),
    .AI_SHIFT(4), .AI_INV(1'b0), .RST_DIV(1)) dut_one (
    .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_data(wr_data),
    .clk_out(co[1]), .bad_prog(bad[1]), .autoidle_en(ai[1]));

  regdiv_clock #(.ENC_MODE(2), .FLD_SHIFT(0), .MIN_DIV(2), .MAX_DIV(16),
    .AI_SHIFT(31), .AI_INV(1'b1), .RST_DIV(2)) dut_pow (
    .clk(clk), .rst(rst), .wr_en(wr_en[2]), .wr_data(wr_data),
    .clk_out(co[2]), .bad_prog(bad[2]), .autoidle_en(ai[2]));

  regdiv_clock #(.FLD_W(2), .ENC_MODE(3), .FLD_SHIFT(0), .MIN_DIV(1),
    .MAX_DIV(16), .AI_SHIFT(8), .AI_INV(1'b0), .RST_DIV(1),
    .DIV_TABLE({8'd16, 8'd0, 8'd8, 8'd4})) dut_tbl (
    .clk(clk), .rst(rst), .wr_en(wr_en[3]), .wr_data(wr_data),
    .clk_out(co[3]), .bad_prog(bad[3]), .autoidle_en(ai[3]));

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // half-cycle sampler of the selected output
  int  seq = 0, last_per = 0, last_hi = 0, c_per = 0, c_hi = 0;
  bit  prev_s = 1'b0, started = 1'b0;

  task automatic take(input bit s);
    if (s && !prev_s) begin
      if (started) begin
        last_per = c_per;
        last_hi  = c_hi;
        seq++;
      end
      c_per = 0;
      c_hi = 0;
      started = 1'b1;
    end
    c_per++;
    if (s) c_hi++;
    prev_s = s;
  endtask

  always begin
    @(posedge clk);
    #5 take(co[sel]);
    #10 take(co[sel]);
  end

  // scoreboard: expected old/new divisors per applied write
  typedef struct { int old_d; int new_d; string tag; } exp_t;
  exp_t q[$];

  always begin
    wait (q.size() > 0);
    begin
      exp_t it;
      int s0;
      it = q[0];
      s0 = seq;
      wait (seq > s0);
      ck(last_per == 2*it.old_d, {"R8 ", it.tag}, last_per, 2*it.old_d);
      s0 = seq;
      wait (seq >= s0 + 2);
      ck(last_per == 2*it.new_d, {"R10 period ", it.tag}, last_per, 2*it.new_d);
      ck(last_hi == ((it.new_d == 1) ? 1 : 2*(it.new_d/2)),
         {"R9/R10 high ", it.tag}, last_hi,
         (it.new_d == 1) ? 1 : 2*(it.new_d/2));
      void'(q.pop_front());
    end
  end

  task automatic wr(input int u, input logic [31:0] d, input bit exp_bad,
                    input bit exp_ai, input int old_d, input int new_d,
                    input string tag);
    exp_t it;
    @(negedge clk);
    wr_data = d;
    wr_en[u] = 1'b1;
    @(posedge clk);
    #2;
    wr_en = '0;
    ck(bad[u] == exp_bad, {"R7 flag ", tag}, bad[u], exp_bad);
    ck(ai[u] == exp_ai, {"R11 autoidle ", tag}, ai[u], exp_ai);
    it.old_d = old_d;
    it.new_d = new_d;
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic pick(input int u);
    sel = u;
    repeat (10) @(posedge clk);
  endtask

  initial begin
    #(CYC*150000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    exp_t it;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #2;
    for (int u = 0; u < 4; u++) begin
      ck(bad[u] == 1'b0, "R12 flag", bad[u], 0);
      ck(ai[u] == 1'b0, "R12 autoidle", ai[u], 0);
    end
    pick(0);
    it.old_d = 1; it.new_d = 1; it.tag = "R12 reset passthrough";
    q.push_back(it);
    wait (q.size() == 0);

    // plus-one encoding, field at bit 8
    wr(0, 32'h0000_0100, 0, 0, 1, 2, "R1 v1");
    wr(0, 32'hFFFF_FAFF, 0, 1, 2, 3, "R5 garbage v2");
    wr(0, 32'h0000_0500, 0, 0, 3, 6, "R1 v5");
    wr(0, 32'h0000_0600, 1, 0, 6, 6, "R6 above max");
    wr(0, 32'h0000_0000, 0, 0, 6, 1, "R9 back to 1");

    // direct encoding, field at bit 24
    pick(1);
    wr(1, 32'h0000_0010, 1, 1, 1, 1, "R2 zero illegal");
    wr(1, 32'h0300_0000, 0, 0, 1, 3, "R2 v3");
    wr(1, 32'h0700_0000, 0, 0, 3, 7, "R2 v7");

    // power of two, min 2, inverted autoidle at bit 31
    pick(2);
    wr(2, 32'h0000_0000, 1, 1, 2, 2, "R6 below min");
    wr(2, 32'h0000_0002, 0, 1, 2, 4, "R3 v2");
    wr(2, 32'h8000_0004, 0, 0, 4, 16, "R3 v4");
    wr(2, 32'h0000_0005, 1, 1, 16, 16, "R3 R6 v5 too big");

    // table {4,8,0,16}
    pick(3);
    wr(3, 32'h0000_0001, 0, 0, 1, 8, "R4 v1");
    wr(3, 32'h0000_0002, 1, 0, 8, 8, "R4 zero entry");
    wr(3, 32'h0000_0003, 0, 0, 8, 16, "R4 v3");
    wr(3, 32'h0000_0100, 0, 1, 16, 4, "R4 v0");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule